// File: doc/BRIEF.md
# Configurable Row Predicate Scanner

The scanner sits in a stream of database rows and keeps only the rows that satisfy a query. A row comes in as a run of bytes, one per clock. Start-of-row and end-of-row flags mark its first and last byte. Every byte is offered to a bank of predicate units at the same time. Each unit picks one field out of the row and compares it against a constant. A binary tree of two-input reducers then folds the unit results into one qualify bit for the row.

The query is loaded at run time, so one built image serves many queries. Through one write port, each predicate unit receives:

- an enable,
- a comparison operator,
- a constant,
- the byte offset of its field,
- the field length.

A second write port sets the operation of each tree node. Configuration writes take effect only between rows.

While a row streams in, its bytes are written speculatively into a buffer that holds one row. If qualify is true when the last byte arrives, the row is played out on a valid/ready/last output port. Otherwise it is dropped and produces no output. While a row is being played out, the input port stalls.

Top module: `row_scan_top`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1. Every unit is disabled and every tree node is AND, so every row qualifies.
- R2: A byte is accepted on a clock where in_valid_i and in_ready_o are both 1. The accepted byte with in_sor_i set has in-row index 0, and the index then counts up by one per accepted byte until the byte with in_eor_i set. A row of one byte carries both flags.
- R3: An enabled unit assembles the bytes at index off .. off+len-1 into a big-endian unsigned value, where len is 1 to FIELD_BYTES. The first byte is the most significant. Idle cycles inside a row do not advance the index.
- R4: Operator codes compare the field F with the constant C. Code 0 is F==C, 1 is F!=C, 2 is F<C, 3 is F<=C, 4 is F>C and 5 is F>=C. Codes 6 and 7 always give false.
- R5: An enabled unit whose field is not complete by the last byte of the row gives false.
- R6: A disabled unit gives logic 1, which is neutral for an AND parent.
- R7: Node operation codes are 0 AND, 1 OR, 2 NOT of the left input, and 3 PASS of the left input. NOT and PASS ignore the right input.
- R8: Node 0 is the root of the tree. Node n takes node 2n+1 as its left input and node 2n+2 as its right input. Tree position NUM_PRED-1+k is unit k.
- R9: A row that qualifies is played out byte-exact in arrival order, with out_last_o on its final byte. A row that fails produces no output beat.
- R10: While a stored row is being played out, in_ready_o is 0. Under out_ready_i low, out_valid_o and out_data_o hold their values.
- R11: A configuration write has no effect while a row is in flight, meaning after its first byte is accepted and until its last byte is accepted. It also has no effect in any cycle where in_valid_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pred_we_i | input | 1 | Write strobe for one predicate unit |
| cfg_pred_idx_i | input | $clog2(NUM_PRED) | Unit selected for the write |
| cfg_pred_en_i | input | 1 | Unit enable |
| cfg_pred_op_i | input | 3 | Comparison operator code |
| cfg_pred_const_i | input | 8*FIELD_BYTES | Comparison constant |
| cfg_pred_off_i | input | $clog2(MAX_ROW) | Byte index of the field's first byte |
| cfg_pred_len_i | input | $clog2(FIELD_BYTES)+1 | Field length in bytes |
| cfg_node_we_i | input | 1 | Write strobe for one tree node |
| cfg_node_idx_i | input | $clog2(NUM_PRED) | Node selected for the write |
| cfg_node_op_i | input | 2 | Node operation code |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte can be taken |
| in_data_i | input | 8 | Input byte |
| in_sor_i | input | 1 | First byte of a row |
| in_eor_i | input | 1 | Last byte of a row |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream takes the output byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of a played-out row |

## Verification
Qualify is settled in the same cycle that the last byte is accepted. A row that qualifies therefore shows its first byte on out_valid_o in the next cycle, and then one byte per cycle in which out_ready_i is high. The monitor drives out_ready_i and samples the output at the falling edge, so each byte is recorded in the cycle of its handshake. Each row is compared with its expected bytes as soon as its last byte has been taken. After every stimulus row, the driver waits until the output is idle and then compares the number of rows that came out with the number the model predicted; this is how dropped rows are checked. While the output is stalled, each cycle is checked for a held byte, and each row's final beat is checked for a low in_ready_o.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [2:0] {
    CMP_EQ = 3'd0,
    CMP_NE = 3'd1,
    CMP_LT = 3'd2,
    CMP_LE = 3'd3,
    CMP_GT = 3'd4,
    CMP_GE = 3'd5
  } cmp_op_e;

  typedef enum logic [1:0] {
    RED_AND  = 2'd0,
    RED_OR   = 2'd1,
    RED_NOT  = 2'd2,
    RED_PASS = 2'd3
  } red_op_e;

endpackage

// File: rtl/pred_unit.sv
module pred_unit
  import row_scan_pkg::*;
#(
  parameter int  FIELD_BYTES = 8,
  parameter int  POS_W       = 6,
  parameter int  LEN_W       = 4,
  parameter bit  DIS_VAL     = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic                     cfg_en_i,
  input  logic [2:0]               cfg_op_i,
  input  logic [8*FIELD_BYTES-1:0] cfg_const_i,
  input  logic [POS_W-1:0]         cfg_off_i,
  input  logic [LEN_W-1:0]         cfg_len_i,
  input  logic                     beat_i,
  input  logic                     sor_i,
  input  logic [POS_W-1:0]         pos_i,
  input  logic [7:0]               byte_i,
  output logic                     res_o
);

  localparam int FW = 8 * FIELD_BYTES;

  logic             en_q;
  logic [2:0]       op_q;
  logic [FW-1:0]    const_q;
  logic [POS_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;
  logic [FW-9:0]    acc_q;
  logic             done_q;
  logic             flag_q;

  logic [POS_W:0]   end_w;
  logic [POS_W:0]   pos_x;
  logic             len_ok;
  logic             in_field;
  logic             last_byte;
  logic [FW-1:0]    acc_nx;
  logic             cmp_w;
  logic             complete;
  logic             done_eff;

  function automatic logic cmp_eval(logic [2:0] op, logic [FW-1:0] a, logic [FW-1:0] b);
    case (op)
      CMP_EQ:  return a == b;
      CMP_NE:  return a != b;
      CMP_LT:  return a <  b;
      CMP_LE:  return a <= b;
      CMP_GT:  return a >  b;
      CMP_GE:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  assign len_ok    = (len_q != '0);
  assign end_w     = {1'b0, off_q} + (POS_W+1)'(len_q) - (POS_W+1)'(1);
  assign pos_x     = {1'b0, pos_i};
  assign in_field  = len_ok && (pos_x >= {1'b0, off_q}) && (pos_x <= end_w);
  assign last_byte = len_ok && (pos_x == end_w);
  assign acc_nx    = (pos_i == off_q) ? FW'(byte_i) : {acc_q, byte_i};
  assign cmp_w     = cmp_eval(op_q, acc_nx, const_q);
  assign complete  = beat_i && last_byte;
  // a new row start hides the previous row's result
  assign done_eff  = done_q && !(beat_i && sor_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      op_q    <= CMP_EQ;
      const_q <= '0;
      off_q   <= '0;
      len_q   <= '0;
    end else if (cfg_we_i) begin
      en_q    <= cfg_en_i;
      op_q    <= cfg_op_i;
      const_q <= cfg_const_i;
      off_q   <= cfg_off_i;
      len_q   <= cfg_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (beat_i) begin
      if (in_field) acc_q <= acc_nx[FW-9:0];
      if (last_byte) begin
        done_q <= 1'b1;
        flag_q <= cmp_w;
      end else if (sor_i) begin
        done_q <= 1'b0;
      end
    end
  end

  assign res_o = !en_q    ? DIS_VAL :
                 done_eff ? flag_q  :
                 complete ? cmp_w   : 1'b0;

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !(beat_i && sor_i) |=> done_q); // R3

endmodule

// File: rtl/reduce_tree.sv
module reduce_tree
  import row_scan_pkg::*;
#(
  parameter int NUM_LEAF = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [1:0]          cfg_op_i,
  input  logic [NUM_LEAF-1:0] leaf_i,
  output logic                qual_o
);

  localparam int LEVELS   = $clog2(NUM_LEAF);
  localparam int NUM_NODE = NUM_LEAF - 1;

  red_op_e op_q [NUM_NODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_NODE; n++) op_q[n] <= RED_AND;
    end else if (cfg_we_i) begin
      for (int n = 0; n < NUM_NODE; n++)
        if (cfg_idx_i == IDX_W'(n)) op_q[n] <= red_op_e'(cfg_op_i);
    end
  end

  // g_lvl[i] holds tree level LEVELS-i; g_lvl[0] is the leaf level
  for (genvar i = 0; i <= LEVELS; i++) begin : g_lvl
    localparam int D = LEVELS - i;
    logic [(1<<D)-1:0] v;
    if (i == 0) begin : g_leaf
      assign v = leaf_i;
    end else begin : g_node
      for (genvar j = 0; j < (1<<D); j++) begin : g_n
        localparam int N = (1<<D) - 1 + j;
        logic l, r;
        assign l = g_lvl[i-1].v[2*j];
        assign r = g_lvl[i-1].v[2*j+1];
        assign v[j] = (op_q[N] == RED_AND) ? (l & r) :
                      (op_q[N] == RED_OR)  ? (l | r) :
                      (op_q[N] == RED_NOT) ? ~l      : l;
      end
    end
  end

  assign qual_o = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/row_buffer.sv
module row_buffer #(
  parameter int MAX_ROW = 64,
  parameter int POS_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       data_i,
  input  logic             eor_i,
  input  logic             qual_i,
  output logic             full_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_last_o
);

  logic [7:0]       mem [MAX_ROW];
  logic             full_q;
  logic [POS_W:0]   len_q;
  logic [POS_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[pos_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      len_q  <= '0;
      rd_q   <= '0;
    end else if (wr_i && eor_i && qual_i) begin
      full_q <= 1'b1;
      len_q  <= {1'b0, pos_i} + (POS_W+1)'(1);
      rd_q   <= '0;
    end else if (full_q && out_ready_i) begin
      if (out_last_o) full_q <= 1'b0;
      else            rd_q   <= rd_q + POS_W'(1);
    end
  end

  assign full_o      = full_q;
  assign out_valid_o = full_q;
  assign out_data_o  = mem[rd_q];
  assign out_last_o  = ({1'b0, rd_q} == len_q - (POS_W+1)'(1));

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R10
  AST_NO_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !wr_i); // R10
  AST_LEN_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (len_q != '0) && (len_q <= (POS_W+1)'(MAX_ROW))); // R9

endmodule

// File: rtl/row_scan_top.sv
module row_scan_top
  import row_scan_pkg::*;
#(
  parameter int NUM_PRED    = 4,
  parameter int FIELD_BYTES = 8,
  parameter int MAX_ROW     = 64,
  parameter bit DIS_VAL     = 1'b1,
  localparam int IDX_W = $clog2(NUM_PRED),
  localparam int POS_W = $clog2(MAX_ROW),
  localparam int LEN_W = $clog2(FIELD_BYTES) + 1,
  localparam int FW    = 8 * FIELD_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_pred_we_i,
  input  logic [IDX_W-1:0] cfg_pred_idx_i,
  input  logic             cfg_pred_en_i,
  input  logic [2:0]       cfg_pred_op_i,
  input  logic [FW-1:0]    cfg_pred_const_i,
  input  logic [POS_W-1:0] cfg_pred_off_i,
  input  logic [LEN_W-1:0] cfg_pred_len_i,
  input  logic             cfg_node_we_i,
  input  logic [IDX_W-1:0] cfg_node_idx_i,
  input  logic [1:0]       cfg_node_op_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  input  logic             in_sor_i,
  input  logic             in_eor_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_last_o
);

  logic                beat;
  logic                full;
  logic                in_row_q;
  logic                cfg_ok;
  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    cur_pos;
  logic [NUM_PRED-1:0] unit_res;
  logic                qual;

  assign in_ready_o = !full;
  assign beat       = in_valid_i && in_ready_o;
  assign cur_pos    = in_sor_i ? '0 : pos_q;
  assign cfg_ok     = !in_row_q && !in_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      in_row_q <= 1'b0;
    end else if (beat) begin
      pos_q    <= cur_pos + POS_W'(1);
      in_row_q <= !in_eor_i;
    end
  end

  for (genvar k = 0; k < NUM_PRED; k++) begin : g_unit
    pred_unit #(
      .FIELD_BYTES(FIELD_BYTES),
      .POS_W      (POS_W),
      .LEN_W      (LEN_W),
      .DIS_VAL    (DIS_VAL)
    ) i_pred_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_pred_we_i && cfg_ok && (cfg_pred_idx_i == IDX_W'(k))),
      .cfg_en_i   (cfg_pred_en_i),
      .cfg_op_i   (cfg_pred_op_i),
      .cfg_const_i(cfg_pred_const_i),
      .cfg_off_i  (cfg_pred_off_i),
      .cfg_len_i  (cfg_pred_len_i),
      .beat_i     (beat),
      .sor_i      (in_sor_i),
      .pos_i      (cur_pos),
      .byte_i     (in_data_i),
      .res_o      (unit_res[k])
    );
  end

  reduce_tree #(
    .NUM_LEAF(NUM_PRED),
    .IDX_W   (IDX_W)
  ) i_reduce_tree (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_node_we_i && cfg_ok),
    .cfg_idx_i(cfg_node_idx_i),
    .cfg_op_i (cfg_node_op_i),
    .leaf_i   (unit_res),
    .qual_o   (qual)
  );

  row_buffer #(
    .MAX_ROW(MAX_ROW),
    .POS_W  (POS_W)
  ) i_row_buffer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (beat),
    .pos_i      (cur_pos),
    .data_i     (in_data_i),
    .eor_i      (in_eor_i),
    .qual_i     (qual),
    .full_o     (full),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_last_o (out_last_o)
  );

  AST_ROW_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat && in_eor_i |=> !in_row_q); // R2

endmodule

// File: tb/test_row_scan_top.sv
module test_row_scan_top;

  localparam int NP = 4;
  localparam int MR = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_pred_we_i = 1'b0;
  logic [1:0]  cfg_pred_idx_i = '0;
  logic        cfg_pred_en_i = 1'b0;
  logic [2:0]  cfg_pred_op_i = '0;
  logic [63:0] cfg_pred_const_i = '0;
  logic [5:0]  cfg_pred_off_i = '0;
  logic [3:0]  cfg_pred_len_i = '0;
  logic        cfg_node_we_i = 1'b0;
  logic [1:0]  cfg_node_idx_i = '0;
  logic [1:0]  cfg_node_op_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        in_sor_i = 1'b0;
  logic        in_eor_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [7:0]  out_data_o;
  logic        out_last_o;

  row_scan_top i_row_scan_top (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic        m_en [NP];
  logic [2:0]  m_op [NP];
  logic [63:0] m_const [NP];
  int          m_off [NP];
  int          m_len [NP];
  logic [1:0]  m_nop [NP-1];

  logic [7:0] row_b [MR];
  int         row_n;

  logic [7:0] exp_bytes [$];
  int         exp_len [$];
  string      exp_tag [$];
  int         exp_rows = 0;
  int         rows_out = 0;

  bit         stall_mode = 0;
  int         cyc = 0;
  logic [7:0] col [MR];
  int         col_n = 0;
  bit         prev_stall = 0;
  logic [7:0] prev_data;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic unit_model(int k);
    logic [63:0] v;
    if (!m_en[k]) return 1'b1;
    if (m_off[k] + m_len[k] > row_n) return 1'b0;
    v = '0;
    for (int i = 0; i < m_len[k]; i++) v = (v << 8) | 64'(row_b[m_off[k]+i]);
    case (m_op[k])
      3'd0: return v == m_const[k];
      3'd1: return v != m_const[k];
      3'd2: return v <  m_const[k];
      3'd3: return v <= m_const[k];
      3'd4: return v >  m_const[k];
      3'd5: return v >= m_const[k];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic qual_model();
    logic t [2*NP-1];
    for (int n = 2*NP-2; n >= 0; n--) begin
      if (n >= NP-1) t[n] = unit_model(n-(NP-1));
      else case (m_nop[n])
        2'd0: t[n] = t[2*n+1] & t[2*n+2];
        2'd1: t[n] = t[2*n+1] | t[2*n+2];
        2'd2: t[n] = ~t[2*n+1];
        default: t[n] = t[2*n+1];
      endcase
    end
    return t[0];
  endfunction

  task automatic cfg_pred(int k, bit en, int op, logic [63:0] c, int off, int len);
    @(negedge clk_i);
    cfg_pred_we_i = 1; cfg_pred_idx_i = 2'(k); cfg_pred_en_i = en;
    cfg_pred_op_i = 3'(op); cfg_pred_const_i = c;
    cfg_pred_off_i = 6'(off); cfg_pred_len_i = 4'(len);
    m_en[k] = en; m_op[k] = 3'(op); m_const[k] = c; m_off[k] = off; m_len[k] = len;
    @(negedge clk_i);
    cfg_pred_we_i = 0;
  endtask

  task automatic cfg_node(int n, int op);
    @(negedge clk_i);
    cfg_node_we_i = 1; cfg_node_idx_i = 2'(n); cfg_node_op_i = 2'(op);
    m_nop[n] = 2'(op);
    @(negedge clk_i);
    cfg_node_we_i = 0;
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NP; k++) cfg_pred(k, 0, 0, 64'd0, 0, 1);
    for (int n = 0; n < NP-1; n++) cfg_node(n, 0);
  endtask

  task automatic set_row(int n, int seed);
    row_n = n;
    for (int i = 0; i < MR; i++) row_b[i] = 8'(seed + i*7 + 1);
  endtask

  // gap_at >= 0 inserts one idle cycle before that byte carrying config writes
  task automatic send_row(int gap_at);
    if (qual_model()) begin
      for (int i = 0; i < row_n; i++) exp_bytes.push_back(row_b[i]);
      exp_len.push_back(row_n);
      exp_rows++;
    end
    for (int i = 0; i < row_n; i++) begin
      if (i == gap_at) begin
        @(negedge clk_i);
        in_valid_i = 0; in_sor_i = 0; in_eor_i = 0;
        cfg_pred_we_i = 1; cfg_pred_idx_i = 0; cfg_pred_en_i = 1;
        cfg_pred_op_i = 3'd1; cfg_pred_const_i = 64'(row_b[0]);
        cfg_pred_off_i = 0; cfg_pred_len_i = 4'd1;
        cfg_node_we_i = 1; cfg_node_idx_i = 0; cfg_node_op_i = 2'd2;
      end
      @(negedge clk_i);
      cfg_pred_we_i = 0; cfg_node_we_i = 0;
      in_valid_i = 1; in_data_i = row_b[i];
      in_sor_i = (i == 0); in_eor_i = (i == row_n-1);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 0; in_sor_i = 0; in_eor_i = 0;
  endtask

  task automatic drain(string tag);
    int t = 0;
    @(negedge clk_i);
    while ((exp_len.size() != 0 || out_valid_o) && t < 3000) begin
      @(negedge clk_i);
      t++;
    end
    check(rows_out == exp_rows, tag, "rows emitted", rows_out, exp_rows);
  endtask

  // monitor: drives ready and records handshakes at the falling edge
  always @(negedge clk_i) begin
    int len;
    bit ok;
    cyc++;
    if (prev_stall) begin
      check(out_valid_o && out_data_o == prev_data, "R10", "held byte", out_data_o, prev_data);
    end
    out_ready_i = stall_mode ? (cyc % 3 == 2) : 1'b1;
    prev_stall = out_valid_o && !out_ready_i;
    prev_data  = out_data_o;
    if (out_valid_o && out_ready_i) begin
      col[col_n] = out_data_o;
      col_n++;
      if (out_last_o) begin
        check(!in_ready_o, "R10", "in_ready during playout", in_ready_o, 0);
        rows_out++;
        if (exp_len.size() == 0) begin
          check(0, "R9", "unexpected row length", col_n, 0);
        end else begin
          len = exp_len.pop_front();
          ok = (len == col_n);
          for (int i = 0; i < len; i++) begin
            if (exp_bytes.size() != 0) begin
              if (i < col_n && col[i] != exp_bytes[0]) ok = 0;
              void'(exp_bytes.pop_front());
            end
          end
          check(ok, "R9", "row content/length", col_n, len);
        end
        col_n = 0;
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NP; k++) begin
      m_en[k] = 0; m_op[k] = 0; m_const[k] = 0; m_off[k] = 0; m_len[k] = 0;
    end
    for (int n = 0; n < NP-1; n++) m_nop[n] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check(out_valid_o == 0, "R1", "out_valid after reset", out_valid_o, 0);
    check(in_ready_o == 1, "R1", "in_ready after reset", in_ready_o, 1);

    // R1 default config passes every row
    set_row(6, 3); send_row(-1); drain("R1");

    // R2 single-byte row, then back-to-back rows
    set_row(1, 9); send_row(-1); drain("R2");
    set_row(5, 20); send_row(-1); set_row(4, 40); send_row(-1); drain("R2");

    // R3 two-byte field at offset 2
    cfg_pred(0, 1, 0, 64'h1234, 2, 2);
    set_row(8, 0); row_b[2] = 8'h12; row_b[3] = 8'h34; send_row(-1); drain("R3");
    row_b[3] = 8'h35; send_row(-1); drain("R3");
    // R3 idle cycles inside a row keep the index
    row_b[3] = 8'h34; send_row(2); drain("R3");
    cfg_pred(0, 1, 0, 64'h1234, 2, 2);

    // R3 full eight-byte field
    cfg_pred(0, 1, 0, 64'h0102030405060708, 1, 8);
    set_row(12, 5);
    for (int i = 0; i < 8; i++) row_b[1+i] = 8'(i+1);
    send_row(-1); drain("R3");
    row_b[8] = 8'h09; send_row(-1); drain("R3");

    // R4 operator sweep below/equal/above constant
    for (int op = 0; op < 8; op++) begin
      cfg_pred(0, 1, op, 64'h34, 5, 1);
      for (int v = 0; v < 3; v++) begin
        set_row(7, op*3+v); row_b[5] = 8'(8'h33 + v);
        send_row(-1); drain("R4");
      end
    end

    // R5 field runs past the end of the row
    cfg_pred(0, 1, 1, 64'd0, 10, 2);
    set_row(8, 2); send_row(-1); drain("R5");
    set_row(11, 2); send_row(-1); drain("R5");
    set_row(12, 2); send_row(-1); drain("R5");

    // R6 disabled unit is neutral
    cfg_pred(0, 0, 0, 64'd0, 0, 1);
    cfg_pred(1, 1, 0, 64'hAA, 0, 1);
    set_row(4, 1); row_b[0] = 8'hAA; send_row(-1); drain("R6");
    row_b[0] = 8'hAB; send_row(-1); drain("R6");

    // R7 / R8 node operations and tree wiring
    cfg_pred(1, 0, 0, 64'd0, 0, 1);
    cfg_pred(0, 1, 0, 64'h11, 0, 1);
    cfg_pred(2, 1, 0, 64'h22, 1, 1);
    cfg_node(0, 1);
    for (int p = 0; p < 4; p++) begin
      set_row(3, 50); row_b[0] = (p & 1) ? 8'h11 : 8'h00; row_b[1] = (p & 2) ? 8'h22 : 8'h00;
      send_row(-1); drain("R7");
    end
    cfg_node(0, 2);
    for (int p = 0; p < 4; p++) begin
      set_row(3, 60); row_b[0] = (p & 1) ? 8'h11 : 8'h00; row_b[1] = (p & 2) ? 8'h22 : 8'h00;
      send_row(-1); drain("R7");
    end
    cfg_node(0, 3);
    for (int p = 0; p < 4; p++) begin
      set_row(3, 70); row_b[0] = (p & 1) ? 8'h11 : 8'h00; row_b[1] = (p & 2) ? 8'h22 : 8'h00;
      send_row(-1); drain("R8");
    end
    cfg_node(0, 0); cfg_node(1, 2);
    for (int p = 0; p < 4; p++) begin
      set_row(3, 80); row_b[0] = (p & 1) ? 8'h11 : 8'h00; row_b[1] = (p & 2) ? 8'h22 : 8'h00;
      send_row(-1); drain("R8");
    end

    // R11 config writes during a row gap are ignored
    clear_cfg();
    cfg_pred(0, 1, 0, 64'h5A, 0, 1);
    cfg_node(0, 3);
    set_row(6, 11); row_b[0] = 8'h5A; send_row(3); drain("R11");
    send_row(-1); drain("R11");

    // R10 backpressure with back-to-back rows, including a full-size row
    clear_cfg();
    stall_mode = 1;
    set_row(10, 90); send_row(-1);
    set_row(MR, 17); send_row(-1);
    set_row(3, 33); send_row(-1);
    drain("R10");
    stall_mode = 0;

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule